// File: doc/BRIEF.md
# Bitstream Window Shifter with Start-Code Seek

This block sits at the head of a variable-length video decoder. It pulls a byte stream from memory through a small fetch port, using a start address and a byte length that the host programs. It keeps a 32-bit left-aligned bit buffer, and the top 16 bits of that buffer form a window that the host can read at any time. The window shows the next 16 bits of the stream.

The host drives the block with commands. A shift command consumes 0 to 16 bits. A seek command advances to the next byte-aligned start code and stops with the code byte in the top half of the window. Each halt records its cause in a sticky status bit and can raise an interrupt. The host reads the status, clears the bits it has handled, and then issues the next command. If the input runs dry, the pending command waits until a new length is programmed, and then it finishes by itself.

Top module: `bit_window_unit`

## Requirements
- R1: When the block is idle and input fetch has settled, the window (register 0, bits 15:0) holds the 16 stream bits that follow the consumed position, with the earliest bit in bit 15. Bits beyond the last byte fetched read as 0.
- R2: A command write to register 3 with opcode 1 in bits 1:0 and an amount N of 0..16 in bits 12:8 advances the stream by N bits. When it completes, it sets the done bit (status bit 0) and goes idle.
- R3: A command with opcode 2 first byte-aligns the stream. It then skips whole bytes until the next three bytes are 0x00,0x00,0x01, consumes those three bytes, and sets status bit 1. The window's bits 15:8 then hold the byte that follows the prefix.
- R4: Opcode 0 or 3, or opcode 1 with an amount above 16, sets the error bit (status bit 2) and leaves the stream position unchanged.
- R5: A pending command sets status bit 3 when it cannot complete and the remaining byte count is 0. The command stays pending (register 3 bit 0 reads 1), the window is unchanged, and the command resumes after a nonzero length is written to register 5.
- R6: While dn_full_i is high, a pending command makes no progress and sets status bit 4. When dn_full_i drops, the command completes.
- R7: Status bits (register 1) are sticky and write-1-to-clear. Writing 1 to a bit clears only that bit, and a new event wins over a clear in the same cycle.
- R8: A command written while the block is busy or while any status bit is set is ignored. The window and the status stay as they were.
- R9: irq_o is high exactly when some status bit is set together with its enable bit in register 2.
- R10: The block raises rd_req_o only while the remaining count is nonzero and at most 24 bits are buffered. Each accepted byte increments the address and decrements the count, so after a length L is written and fetch settles, register 5 reads L-4.
- R11: After reset the window, status, enables, count and irq_o are all 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index (0 window, 1 status, 2 enables, 3 command/busy, 4 address, 5 length) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| rd_req_o | output | 1 | Fetch request (ready for a byte) |
| rd_addr_o | output | 32 | Byte address of the next fetch |
| rd_valid_i | input | 1 | Byte on rd_data_i is valid; it is taken when rd_req_o is also high |
| rd_data_i | input | 8 | Fetched byte |
| dn_full_i | input | 1 | Downstream consumer full |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest situation to reach is a seek that runs out of input partway through, followed by a resume from a second buffer. The bench programs a short first buffer that holds no start code. It starts the seek from an unaligned bit position, so the search exhausts the count and stalls while busy. The bench then programs a second buffer whose bytes carry a plain prefix and also a prefix preceded by an extra zero byte. It checks that the resumed search lands on the expected code byte and on the expected bit position.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_SEEK  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_SHIFT = 2'd1,
    CS_SEEK  = 2'd2
  } cstate_e;

  localparam int NUM_ST     = 5;
  localparam int ST_DONE    = 0;
  localparam int ST_START   = 1;
  localparam int ST_ERR     = 2;
  localparam int ST_INEMPTY = 3;
  localparam int ST_OUTFULL = 4;

  localparam logic [2:0] RA_WIN  = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_IEN  = 3'd2;
  localparam logic [2:0] RA_CMD  = 3'd3;
  localparam logic [2:0] RA_BASE = 3'd4;
  localparam logic [2:0] RA_LEN  = 3'd5;

  localparam logic [23:0] SC_PREFIX = 24'h000001;
endpackage

// File: rtl/bws_fetch.sv
module bws_fetch #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic              len_we_i,
  input  logic [31:0]       wdata_i,
  input  logic              room_i,
  input  logic              rd_valid_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [LEN_W-1:0]  left_o,
  output logic              accept_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;

  assign rd_req_o  = room_i && (left_q != '0);
  assign accept_o  = rd_req_o && rd_valid_i;
  assign rd_addr_o = addr_q;
  assign left_o    = left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
    end else begin
      if (base_we_i)     addr_q <= wdata_i[ADDR_W-1:0];
      else if (accept_o) addr_q <= addr_q + 1'b1;
      if (len_we_i)      left_q <= wdata_i[LEN_W-1:0];
      else if (accept_o) left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/bws_shreg.sv
module bws_shreg #(
  parameter int BUF_W = 32,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic [CNT_W-1:0] shift_amt_i,
  input  logic             in_en_i,
  input  logic [7:0]       in_byte_i,
  output logic [BUF_W-1:0] buf_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [2:0]       phase_o,
  output logic             room_o
);
  logic [BUF_W-1:0] buf_q, buf_s, buf_n;
  logic [CNT_W-1:0] cnt_q, cnt_s, cnt_n;
  logic [2:0]       phase_q;
  logic [BUF_W-1:0] ins;

  always_comb begin
    buf_s = buf_q;
    cnt_s = cnt_q;
    if (shift_en_i) begin
      buf_s = buf_q << shift_amt_i;
      cnt_s = cnt_q - shift_amt_i;
    end
    // new byte lands just below the last valid bit after this cycle's shift
    ins   = {in_byte_i, {(BUF_W-8){1'b0}}} >> cnt_s;
    buf_n = in_en_i ? (buf_s | ins) : buf_s;
    cnt_n = in_en_i ? (cnt_s + CNT_W'(8)) : cnt_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      buf_q <= buf_n;
      cnt_q <= cnt_n;
      if (shift_en_i) phase_q <= phase_q + shift_amt_i[2:0];
    end
  end

  assign buf_o   = buf_q;
  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
  assign room_o  = (cnt_q <= CNT_W'(BUF_W - 8));
endmodule

// File: rtl/bws_ctrl.sv
module bws_ctrl
  import bws_pkg::*;
#(
  parameter int BUF_W = 32,
  parameter int WIN_W = 16,
  localparam int CNT_W = $clog2(BUF_W + 1),
  localparam int AMT_W = $clog2(WIN_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [AMT_W-1:0]  cmd_amt_i,
  input  logic [4:0]        cmd_amt_raw_i,
  input  logic              stat_we_i,
  input  logic [NUM_ST-1:0] stat_clr_i,
  input  logic [NUM_ST-1:0] ien_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [2:0]        phase_i,
  input  logic [23:0]       top_i,
  input  logic              left_zero_i,
  input  logic              dn_full_i,
  output logic              shift_en_o,
  output logic [CNT_W-1:0]  shift_amt_o,
  output logic [NUM_ST-1:0] status_o,
  output logic              busy_o,
  output logic              irq_o
);
  cstate_e           state_q, state_n;
  logic [CNT_W-1:0]  amt_q, amt_n;
  logic [NUM_ST-1:0] status_q, set;
  logic [CNT_W-1:0]  align_amt;
  logic              amt_ok;

  assign align_amt = CNT_W'(8) - CNT_W'(phase_i);
  assign amt_ok    = ({1'b0, cmd_amt_raw_i} <= 6'(WIN_W));

  always_comb begin
    state_n     = state_q;
    amt_n       = amt_q;
    set         = '0;
    shift_en_o  = 1'b0;
    shift_amt_o = '0;
    unique case (state_q)
      CS_IDLE: begin
        if (cmd_we_i && status_q == '0) begin
          if (cmd_op_i == OP_SHIFT && amt_ok) begin
            state_n = CS_SHIFT;
            amt_n   = CNT_W'(cmd_amt_i);
          end else if (cmd_op_i == OP_SEEK) begin
            state_n = CS_SEEK;
          end else begin
            set[ST_ERR] = 1'b1;
          end
        end
      end
      CS_SHIFT: begin
        if (dn_full_i) begin
          set[ST_OUTFULL] = 1'b1;
        end else if (cnt_i >= amt_q) begin
          shift_en_o    = 1'b1;
          shift_amt_o   = amt_q;
          set[ST_DONE]  = 1'b1;
          state_n       = CS_IDLE;
        end else if (left_zero_i) begin
          set[ST_INEMPTY] = 1'b1;
        end
      end
      CS_SEEK: begin
        if (dn_full_i) begin
          set[ST_OUTFULL] = 1'b1;
        end else if (phase_i != 3'd0) begin
          if (cnt_i >= align_amt) begin
            shift_en_o  = 1'b1;
            shift_amt_o = align_amt;
          end else if (left_zero_i) begin
            set[ST_INEMPTY] = 1'b1;
          end
        end else if (cnt_i == CNT_W'(BUF_W)) begin
          shift_en_o = 1'b1;
          if (top_i == SC_PREFIX) begin
            shift_amt_o   = CNT_W'(24);
            set[ST_START] = 1'b1;
            state_n       = CS_IDLE;
          end else begin
            shift_amt_o = CNT_W'(8);
          end
        end else if (left_zero_i) begin
          set[ST_INEMPTY] = 1'b1;
        end
      end
      default: state_n = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CS_IDLE;
      amt_q    <= '0;
      status_q <= '0;
    end else begin
      state_q  <= state_n;
      amt_q    <= amt_n;
      status_q <= (status_q & ~(stat_we_i ? stat_clr_i : '0)) | set;
    end
  end

  assign status_o = status_q;
  assign busy_o   = (state_q != CS_IDLE);
  assign irq_o    = |(status_q & ien_i);
endmodule

// File: rtl/bit_window_unit.sv
module bit_window_unit
  import bws_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int WIN_W  = 16,
  localparam int BUF_W = 2 * WIN_W,
  localparam int CNT_W = $clog2(BUF_W + 1),
  localparam int AMT_W = $clog2(WIN_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  input  logic              dn_full_i,
  output logic              irq_o
);
  logic              base_we, len_we, cmd_we, stat_we, ien_we;
  logic [NUM_ST-1:0] ien_q, status_w;
  logic              busy_w, room_w, accept_w, shift_en_w;
  logic [CNT_W-1:0]  cnt_w, shift_amt_w;
  logic [2:0]        phase_w;
  logic [BUF_W-1:0]  buf_w;
  logic [LEN_W-1:0]  left_w;

  assign base_we = reg_we_i && reg_addr_i == RA_BASE;
  assign len_we  = reg_we_i && reg_addr_i == RA_LEN;
  assign cmd_we  = reg_we_i && reg_addr_i == RA_CMD;
  assign stat_we = reg_we_i && reg_addr_i == RA_STAT;
  assign ien_we  = reg_we_i && reg_addr_i == RA_IEN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (ien_we) ien_q <= reg_wdata_i[NUM_ST-1:0];
  end

  bws_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk_i, .rst_ni,
    .base_we_i (base_we),
    .len_we_i  (len_we),
    .wdata_i   (reg_wdata_i),
    .room_i    (room_w),
    .rd_valid_i,
    .rd_req_o,
    .rd_addr_o,
    .left_o    (left_w),
    .accept_o  (accept_w)
  );

  bws_shreg #(.BUF_W(BUF_W)) u_shreg (
    .clk_i, .rst_ni,
    .shift_en_i  (shift_en_w),
    .shift_amt_i (shift_amt_w),
    .in_en_i     (accept_w),
    .in_byte_i   (rd_data_i),
    .buf_o       (buf_w),
    .cnt_o       (cnt_w),
    .phase_o     (phase_w),
    .room_o      (room_w)
  );

  bws_ctrl #(.BUF_W(BUF_W), .WIN_W(WIN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_we_i      (cmd_we),
    .cmd_op_i      (reg_wdata_i[1:0]),
    .cmd_amt_i     (reg_wdata_i[8 +: AMT_W]),
    .cmd_amt_raw_i (reg_wdata_i[12:8]),
    .stat_we_i     (stat_we),
    .stat_clr_i    (reg_wdata_i[NUM_ST-1:0]),
    .ien_i         (ien_q),
    .cnt_i         (cnt_w),
    .phase_i       (phase_w),
    .top_i         (buf_w[BUF_W-1 -: 24]),
    .left_zero_i   (left_w == '0),
    .dn_full_i,
    .shift_en_o    (shift_en_w),
    .shift_amt_o   (shift_amt_w),
    .status_o      (status_w),
    .busy_o        (busy_w),
    .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_WIN:  reg_rdata_o = 32'(buf_w[BUF_W-1 -: WIN_W]);
      RA_STAT: reg_rdata_o = 32'(status_w);
      RA_IEN:  reg_rdata_o = 32'(ien_q);
      RA_CMD:  reg_rdata_o = 32'(busy_w);
      RA_BASE: reg_rdata_o = 32'(rd_addr_o);
      RA_LEN:  reg_rdata_o = 32'(left_w);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bws_checker.sv
module bws_checker
  import bws_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BUF_W  = 32,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              accept_w,
  input logic              base_we,
  input logic              stat_we,
  input logic [NUM_ST-1:0] status_w,
  input logic              busy_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [2:0]        phase_w,
  input logic [LEN_W-1:0]  left_w
);
  a_r9_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_w != '0));

  a_r10_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (left_w != '0 && cnt_w <= CNT_W'(BUF_W - 8)));

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w <= CNT_W'(BUF_W));

  a_r10_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && !base_we) |=> rd_addr_o == $past(rd_addr_o) + 1'b1);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we |=> ((status_w & $past(status_w)) == $past(status_w)));

  a_r2_done_goes_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_w[ST_DONE]) |-> !busy_w);

  a_r3_start_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_w[ST_START]) |-> (phase_w == 3'd0 && !busy_w));
endmodule

bind bit_window_unit bws_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_W(BUF_W)) u_chk (
  .clk_i, .rst_ni, .irq_o, .rd_req_o, .rd_addr_o,
  .accept_w, .base_we, .stat_we, .status_w, .busy_w,
  .cnt_w, .phase_w, .left_w
);

// File: tb/bit_window_unit_tb_top.sv
module bit_window_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_req, irq;
  logic [31:0] rd_addr;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        dn_full = 1'b0;
  logic        vmode = 1'b0;
  int unsigned vcnt = 0;

  int errors = 0, checks = 0;
  int pos = 0, avail = 0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;
  always @(negedge clk) vcnt <= vcnt + 1;
  assign rd_valid = vmode ? (vcnt[0] ^ vcnt[2]) : 1'b1;
  assign rd_data  = mem[rd_addr[7:0]];

  bit_window_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rd_req_o(rd_req),
    .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .dn_full_i(dn_full), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_win(input int p);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) begin
      int b;
      b = p + i;
      w[15-i] = (b < avail) ? mem[b/8][7-(b%8)] : 1'b0;
    end
    return w;
  endfunction

  task automatic wait_stat(input logic [4:0] mask, output logic [31:0] s);
    for (int i = 0; i < 4000; i++) begin
      rd(3'd1, s);
      if ((s[4:0] & mask) != 0) break;
    end
  endtask

  task automatic do_shift(input int n, input string req);
    logic [31:0] s, w;
    wr(3'd3, 32'((n << 8) | 1));
    wait_stat(5'h01, s);
    chk(req, s, 32'h1);
    pos += n;
    idle(12);
    rd(3'd0, w);
    chk("R1", w, 32'(exp_win(pos)));
    wr(3'd1, 32'h1f);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired (R2 progress)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s, w, b;
    for (int a = 0; a < 256; a++) mem[a] = 8'(((a * 73 + 29) & 8'hff) | 8'h80);
    mem[60] = 8'h00; mem[61] = 8'h00; mem[62] = 8'h01; mem[63] = 8'hB3;
    mem[80] = 8'h00; mem[81] = 8'h00; mem[82] = 8'h00; mem[83] = 8'h01; mem[84] = 8'h47;

    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R11 reset state
    rd(3'd0, w); chk("R11", w, 0);
    rd(3'd1, s); chk("R11", s, 0);
    rd(3'd5, w); chk("R11", w, 0);
    rd(3'd3, w); chk("R11", w, 0);
    chk("R11", 32'(irq), 0);
    chk("R10", 32'(rd_req), 0);

    // R10 fetch gating: 4 bytes fill the buffer
    avail = 40 * 8;
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd40);
    idle(20);
    rd(3'd5, w); chk("R10", w, 36);
    rd(3'd4, w); chk("R10", w, 4);
    chk("R10", 32'(rd_req), 0);
    rd(3'd0, w); chk("R1", w, 32'(exp_win(0)));

    // R2 sweep of every legal amount, with a bursty fetch
    vmode = 1'b1;
    for (int n = 1; n <= 16; n++) do_shift(n, "R2");
    do_shift(0, "R2");
    chk("R9", 32'(irq), 0);

    // R8 command ignored while a status bit is set
    wr(3'd3, 32'h0401);
    wait_stat(5'h01, s);
    pos += 4;
    idle(12);
    wr(3'd3, 32'h0501);
    idle(12);
    rd(3'd0, w); chk("R8", w, 32'(exp_win(pos)));
    rd(3'd1, s); chk("R8", s, 32'h1);
    rd(3'd3, w); chk("R8", w, 0);
    wr(3'd1, 32'h1f);

    // R9 interrupt enable
    wr(3'd2, 32'h01);
    wr(3'd3, 32'h0301);
    wait_stat(5'h01, s);
    pos += 3;
    idle(2);
    chk("R9", 32'(irq), 1);
    wr(3'd1, 32'h01);
    idle(1);
    chk("R9", 32'(irq), 0);
    rd(3'd1, s); chk("R7", s, 0);

    // R4 errors: amount too big, reserved opcodes
    wr(3'd3, 32'h1101);
    idle(2);
    rd(3'd1, s); chk("R4", s, 32'h4);
    rd(3'd0, w); chk("R4", w, 32'(exp_win(pos)));
    wr(3'd1, 32'h04);
    wr(3'd3, 32'h0003);
    idle(2);
    rd(3'd1, s); chk("R4", s, 32'h4);
    wr(3'd1, 32'h04);
    wr(3'd3, 32'h0000);
    idle(2);
    rd(3'd1, s); chk("R4", s, 32'h4);
    rd(3'd0, w); chk("R4", w, 32'(exp_win(pos)));
    wr(3'd1, 32'h04);

    // R5/R3 unaligned seek that exhausts the first buffer
    wr(3'd2, 32'h08);
    wr(3'd3, 32'h0002);
    wait_stat(5'h1f, s);
    chk("R5", s, 32'h8);
    rd(3'd3, w); chk("R5", w, 1);
    idle(1);
    chk("R9", 32'(irq), 1);
    avail = 256 * 8;
    wr(3'd4, 32'd40);
    wr(3'd5, 32'd216);
    wr(3'd1, 32'h08);
    wait_stat(5'h02, s);
    chk("R3", s, 32'h2);
    pos = 63 * 8;
    idle(12);
    rd(3'd0, w);
    chk("R3", 32'(w[15:8]), 32'hB3);
    chk("R3", w, 32'(exp_win(pos)));
    wr(3'd1, 32'h02);
    do_shift(8, "R2");

    // R3 prefix preceded by an extra zero byte
    wr(3'd3, 32'h0002);
    wait_stat(5'h1f, s);
    chk("R3", s, 32'h2);
    pos = 84 * 8;
    idle(12);
    rd(3'd0, w);
    chk("R3", 32'(w[15:8]), 32'h47);
    chk("R3", w, 32'(exp_win(pos)));
    wr(3'd1, 32'h02);

    // R6 downstream full pauses a shift
    dn_full = 1'b1;
    wr(3'd3, 32'h0501);
    idle(6);
    rd(3'd1, s); chk("R6", s, 32'h10);
    rd(3'd3, w); chk("R6", w, 1);
    dn_full = 1'b0;
    wait_stat(5'h01, s);
    chk("R6", s, 32'h11);
    pos += 5;
    wr(3'd1, 32'h10);
    rd(3'd1, s); chk("R7", s, 32'h01);
    idle(12);
    rd(3'd0, w); chk("R1", w, 32'(exp_win(pos)));
    wr(3'd1, 32'h01);

    // R1 run to the end of input; tail bits read as zero
    while (pos + 16 <= avail) do_shift(16, "R2");
    b = 32'(pos);
    do_shift(0, "R1");
    wr(3'd3, 32'h1001);
    wait_stat(5'h1f, s);
    chk("R5", s, 32'h8);
    rd(3'd3, w); chk("R5", w, 1);
    rd(3'd0, w); chk("R5", w, 32'(exp_win(int'(b))));
    rd(3'd5, w); chk("R5", w, 0);
    chk("R9", 32'(irq), 1);
    // R8 command while busy is ignored
    wr(3'd1, 32'h08);
    wr(3'd3, 32'h0101);
    idle(3);
    rd(3'd0, w); chk("R8", w, 32'(exp_win(int'(b))));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule